// File: doc/BRIEF.md
# Long-Mode Interrupt Gate Validator

This block sits in the interrupt delivery path. It works out where a vector's gate lives in the descriptor table. It checks the 16-byte gate it is given, together with the attributes of the code segment that the gate names, and reports whether delivery may go on. The caller pulses `start` with the vector, the fetched 128-bit gate and the target segment's long and default-size bits. One clock later `res_valid` rises, and the block presents:

- the table byte offset;
- the assembled 64-bit handler pointer;
- the stack-table selector;
- a trap-gate flag;
- a general-protection fault indication with its error code and a fault-kind tag.

The gate is read as little-endian bytes: byte *i* is `gate[8i+7:8i]`. Fetching the gate, looking up the segment, checking privilege and pushing the frame are handled elsewhere.

Control is a two-state machine:

- `ST_IDLE`: no result is held valid.
- `ST_REPORT`: a result is on the outputs and `res_valid` is high.

It has three transitions:

- `GO` (`ST_IDLE` to `ST_REPORT` on `start`).
- `AGAIN` (`ST_REPORT` to `ST_REPORT` on `start`, which loads a new result).
- `DONE` (`ST_REPORT` to `ST_IDLE` when `start` is low).

Top module: `igate_checker`

## Requirements
- R1: `table_offset` equals `vector` multiplied by 16 (vector in bits above four zero bits). It is registered with the result.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `start` is high, and low otherwise. The result outputs are loaded only on `start`.
- R3: `target_ip[15:0]` is `gate[15:0]`, `target_ip[31:16]` is `gate[63:48]`, and `target_ip[63:32]` is `gate[95:64]`. All other gate bits have no effect on any output except as stated in R4 and R5.
- R4: `ist_sel` is `gate[36:32]`. The gate type is `gate[43:40]`. `gate_is_trap` is 1 exactly when the type is 0xF.
- R5: Types 0xE and 0xF pass the type check. Types 0x6 and 0x7 fail it, raising `fault` with `fault_kind`=1 and `fault_code`=0.
- R6: Every other type value also fails the type check, with `fault_kind`=1 and `fault_code`=0.
- R7: A pointer whose bits 63:47 are not all equal is non-canonical. It raises `fault` with `fault_kind`=2 and `fault_code`=0.
- R8: The target segment passes only when `cs_long`=1 and `cs_dflt`=0. Otherwise the block raises `fault` with `fault_kind`=3 and `fault_code` = vector×8+2.
- R9: The checks run in the order type, then canonical form, then segment. Only the first failure is reported. With no failure, `fault`=0, `fault_kind`=0 and `fault_code`=0.
- R10: After reset, `res_valid`, `fault`, `fault_kind` and `fault_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request: evaluate this cycle's inputs |
| vector | input | VEC_W (8) | Interrupt vector |
| gate | input | 128 | Fetched gate descriptor |
| cs_long | input | 1 | Target segment long-mode bit |
| cs_dflt | input | 1 | Target segment default-size bit |
| res_valid | output | 1 | Result valid (one cycle after start) |
| table_offset | output | VEC_W+4 (12) | Gate byte offset in the table |
| target_ip | output | 64 | Assembled handler pointer |
| ist_sel | output | IST_W (5) | Stack-table selector field |
| gate_is_trap | output | 1 | Gate type is trap (0xF) |
| fault | output | 1 | General-protection fault |
| fault_kind | output | 2 | 0 none, 1 type, 2 canonical, 3 segment |
| fault_code | output | CODE_W (16) | Fault error code |

## Verification
The bench builds the block with its defaults: an 8-bit vector, a 48-bit virtual address width and a 16-bit error code. With these values all 256 vectors and all 16 type codes are small enough to sweep in full. Every type is crossed with canonical-low, canonical-high and non-canonical pointers and with all four segment-bit combinations, so each branch of the priority chain is reached. Unused gate bits are filled with noise to show that they are ignored.

// File: rtl/igc_pkg.sv
package igc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } igc_state_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_TYPE  = 2'd1,
        FK_CANON = 2'd2,
        FK_SEG   = 2'd3
    } igc_fault_e;

    localparam logic [3:0] TYPE_INT64  = 4'hE;
    localparam logic [3:0] TYPE_TRAP64 = 4'hF;

    localparam int PTR_W = 64;

endpackage

// File: rtl/igc_field_split.sv
module igc_field_split #(
    parameter int IST_W = 5
) (
    input  logic [127:0]                gate,
    output logic [igc_pkg::PTR_W-1:0]   ip,
    output logic [3:0]                  gtype,
    output logic [IST_W-1:0]            ist
);
    // Pointer pieces: low word, middle word, upper doubleword
    localparam int LO_BASE  = 0;
    localparam int MID_BASE = 48;
    localparam int HI_BASE  = 64;
    localparam int TY_BASE  = 40;
    localparam int IST_BASE = 32;

    always_comb begin
        ip          = '0;
        ip[15:0]    = gate[LO_BASE  +: 16];
        ip[31:16]   = gate[MID_BASE +: 16];
        ip[63:32]   = gate[HI_BASE  +: 32];
        gtype       = gate[TY_BASE  +: 4];
        ist         = gate[IST_BASE +: IST_W];
    end
endmodule

// File: rtl/igc_verdict.sv
module igc_verdict #(
    parameter int VEC_W  = 8,
    parameter int VA_W   = 48,
    parameter int CODE_W = 16
) (
    input  logic [VEC_W-1:0]            vector,
    input  logic [igc_pkg::PTR_W-1:0]   ip,
    input  logic [3:0]                  gtype,
    input  logic                        cs_long,
    input  logic                        cs_dflt,
    output igc_pkg::igc_fault_e         kind,
    output logic [CODE_W-1:0]           code
);
    import igc_pkg::*;

    localparam int TOP_W = PTR_W - VA_W + 1;

    logic type_ok, canon_ok, seg_ok;
    logic [TOP_W-1:0] top_bits;
    logic [CODE_W-1:0] vec_code;

    assign top_bits = ip[PTR_W-1:VA_W-1];
    assign type_ok  = (gtype == TYPE_INT64) || (gtype == TYPE_TRAP64);
    assign canon_ok = (&top_bits) || ~(|top_bits);
    assign seg_ok   = cs_long && !cs_dflt;

    always_comb begin
        vec_code = '0;
        vec_code[VEC_W+2:0] = {vector, 3'b010};
    end

    always_comb begin
        kind = FK_NONE;
        code = '0;
        if (!type_ok) begin
            kind = FK_TYPE;
        end else if (!canon_ok) begin
            kind = FK_CANON;
        end else if (!seg_ok) begin
            kind = FK_SEG;
            code = vec_code;
        end
    end
endmodule

// File: rtl/igate_checker.sv
module igate_checker #(
    parameter int VEC_W  = 8,
    parameter int IST_W  = 5,
    parameter int VA_W   = 48,
    parameter int CODE_W = 16,
    localparam int OFS_W = VEC_W + 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [VEC_W-1:0]            vector,
    input  logic [127:0]                gate,
    input  logic                        cs_long,
    input  logic                        cs_dflt,
    output logic                        res_valid,
    output logic [OFS_W-1:0]            table_offset,
    output logic [igc_pkg::PTR_W-1:0]   target_ip,
    output logic [IST_W-1:0]            ist_sel,
    output logic                        gate_is_trap,
    output logic                        fault,
    output logic [1:0]                  fault_kind,
    output logic [CODE_W-1:0]           fault_code
);
    import igc_pkg::*;

    igc_state_e state_q, state_d;

    logic [PTR_W-1:0]  dec_ip;
    logic [3:0]        dec_type;
    logic [IST_W-1:0]  dec_ist;
    igc_fault_e        chk_kind;
    logic [CODE_W-1:0] chk_code;

    igc_field_split #(.IST_W(IST_W)) u_split (
        .gate  (gate),
        .ip    (dec_ip),
        .gtype (dec_type),
        .ist   (dec_ist)
    );

    igc_verdict #(.VEC_W(VEC_W), .VA_W(VA_W), .CODE_W(CODE_W)) u_verdict (
        .vector  (vector),
        .ip      (dec_ip),
        .gtype   (dec_type),
        .cs_long (cs_long),
        .cs_dflt (cs_dflt),
        .kind    (chk_kind),
        .code    (chk_code)
    );

    // Next-state logic: GO, AGAIN, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = start ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on each request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_offset <= '0;
            target_ip    <= '0;
            ist_sel      <= '0;
            gate_is_trap <= 1'b0;
            fault_kind   <= FK_NONE;
            fault_code   <= '0;
        end else if (start) begin
            table_offset <= {vector, 4'b0000};
            target_ip    <= dec_ip;
            ist_sel      <= dec_ist;
            gate_is_trap <= (dec_type == TYPE_TRAP64);
            fault_kind   <= chk_kind;
            fault_code   <= chk_code;
        end
    end

    assign res_valid = (state_q == ST_REPORT);
    assign fault     = (fault_kind != FK_NONE);

endmodule

// File: rtl/igc_props.sv
module igc_props #(
    parameter int VEC_W  = 8,
    parameter int VA_W   = 48,
    parameter int CODE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [VEC_W-1:0]   vector,
    input logic               res_valid,
    input logic [VEC_W+3:0]   table_offset,
    input logic [63:0]        target_ip,
    input logic               fault,
    input logic [1:0]         fault_kind,
    input logic [CODE_W-1:0]  fault_code
);
    // R2
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> res_valid);
    // R2
    valid_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid);
    // R1
    offset_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (table_offset == {$past(vector), 4'b0000}));
    // R7
    pass_is_canonical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !fault) |->
        ((&target_ip[63:VA_W-1]) || !(|target_ip[63:VA_W-1])));
    // R8
    seg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start ##1 (fault_kind == 2'd3)) |->
        (fault_code == CODE_W'({$past(vector), 3'b010})));
    // R9
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && fault_kind != 2'd3) |-> (fault_code == '0));
endmodule

bind igate_checker igc_props #(.VEC_W(VEC_W), .VA_W(VA_W), .CODE_W(CODE_W)) u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .vector       (vector),
    .res_valid    (res_valid),
    .table_offset (table_offset),
    .target_ip    (target_ip),
    .fault        (fault),
    .fault_kind   (fault_kind),
    .fault_code   (fault_code)
);

// File: tb/sim_igate_checker.sv
module sim_igate_checker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0]   vector = '0;
    logic [127:0] gate = '0;
    logic cs_long = 1'b0, cs_dflt = 1'b0;
    logic res_valid, gate_is_trap, fault;
    logic [11:0] table_offset;
    logic [63:0] target_ip;
    logic [4:0]  ist_sel;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    igate_checker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .gate(gate),
        .cs_long(cs_long), .cs_dflt(cs_dflt), .res_valid(res_valid),
        .table_offset(table_offset), .target_ip(target_ip), .ist_sel(ist_sel),
        .gate_is_trap(gate_is_trap), .fault(fault), .fault_kind(fault_kind),
        .fault_code(fault_code)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_gate(input logic [63:0] ip, input logic [3:0] t,
                                             input logic [4:0] ist, input logic [7:0] salt);
        logic [127:0] g;
        g = {32'hDEAD_0000 | {24'h0, salt}, 128'h0} >> 0;
        g[127:96] = 32'hC0DE_0000 ^ {24'h0, salt};
        g[31:16]  = {salt, ~salt};
        g[39:37]  = salt[2:0];
        g[47:44]  = ~salt[3:0];
        g[15:0]   = ip[15:0];
        g[63:48]  = ip[31:16];
        g[95:64]  = ip[63:32];
        g[43:40]  = t;
        g[36:32]  = ist;
        return g;
    endfunction

    task automatic run(input logic [7:0] v, input logic [63:0] ip, input logic [3:0] t,
                       input logic [4:0] ist, input logic L, input logic D, input bit noncanon);
        logic [1:0]  ek;
        logic [15:0] ec;
        @(negedge clk);
        vector = v; gate = mk_gate(ip, t, ist, v ^ 8'h5A);
        cs_long = L; cs_dflt = D; start = 1'b1;
        ek = 2'd0; ec = 16'd0;
        if (!(t == 4'hE || t == 4'hF)) ek = 2'd1;            // R5 R6
        else if (noncanon)               ek = 2'd2;            // R7
        else if (!(L && !D)) begin ek = 2'd3; ec = {5'd0, v, 3'd0} + 16'd2; end // R8
        @(negedge clk);
        start = 1'b0;
        gate = ~gate; vector = ~v;                             // R2: must not disturb result
        chk("R2 valid", 64'(res_valid), 64'd1);
        chk("R1 offset", 64'(table_offset), 64'(v) * 16);
        chk("R3 pointer", target_ip, ip);
        chk("R4 ist", 64'(ist_sel), 64'(ist));
        chk("R4 trap", 64'(gate_is_trap), 64'(t == 4'hF));
        chk("R9 kind", 64'(fault_kind), 64'(ek));
        chk("R9 code", 64'(fault_code), 64'(ec));
        chk("R9 fault", 64'(fault), 64'(ek != 2'd0));
        @(negedge clk);
        chk("R2 drop", 64'(res_valid), 64'd0);
        chk("R2 hold", target_ip, ip);
    endtask

    initial begin
        #40000000;
        if (!finished) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid", 64'(res_valid), 64'd0);
        chk("R10 fault", 64'(fault), 64'd0);
        chk("R10 kind", 64'(fault_kind), 64'd0);
        chk("R10 code", 64'(fault_code), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle", 64'(res_valid), 64'd0);

        // R1 all vectors with a passing gate
        for (int v = 0; v < 256; v++)
            run(v[7:0], 64'h0000_1234_5678_9ABC ^ (64'(v) << 8), 4'hE, v[4:0], 1'b1, 1'b0, 0);

        // R5 R6 R7 R8 R9 sweep: every type x pointer class x segment bits
        for (int t = 0; t < 16; t++)
            for (int p = 0; p < 3; p++)
                for (int s = 0; s < 4; s++) begin
                    logic [63:0] ip;
                    logic [7:0]  v;
                    v = 8'((t * 13 + p * 7 + s * 29) & 255);
                    case (p)
                        0: ip = 64'h0000_7FFF_FFFF_F000 - 64'(t);       // canonical low
                        1: ip = 64'hFFFF_8000_0000_0010 + 64'(s);       // canonical high
                        default: ip = (s[0]) ? 64'h0000_8000_0000_0000  // bit 47 only
                                             : 64'h0001_0000_0000_0040; // bit 48 only
                    endcase
                    run(v, ip, t[3:0], 5'(t + s), s[1], s[0], p == 2);
                end

        // R2 back-to-back requests: valid stays high, result follows each
        @(negedge clk);
        vector = 8'h21; gate = mk_gate(64'h10, 4'hF, 5'd3, 8'h1);
        cs_long = 1'b1; cs_dflt = 1'b0; start = 1'b1;
        @(negedge clk);
        chk("R2 b2b first", 64'(gate_is_trap), 64'd1);
        vector = 8'hFF; gate = mk_gate(64'h20, 4'hE, 5'd4, 8'h2);
        cs_long = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R2 b2b valid", 64'(res_valid), 64'd1);
        chk("R8 b2b code", 64'(fault_code), 64'h7FA);
        chk("R1 b2b offset", 64'(table_offset), 64'hFF0);
        @(negedge clk);
        chk("R2 b2b drop", 64'(res_valid), 64'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule